// File: doc/BRIEF.md
# Sigma-Delta Bitstream Receiver

This block sits between an external one-bit sigma-delta modulator and a decimation filter. It accepts the modulator's serial stream in one of four line formats and delivers each recovered bit to the filter as a signed unit sample (+1 or -1) with a valid strobe. Two formats are clocked: the bit is captured on the rising or on the falling edge of a serial clock. The other two are self-clocked Manchester codes with opposite polarity conventions. For these the decoder recovers bit timing from the line itself, measured against a programmable count of system clocks per half bit.

For the clocked formats the serial clock is chosen from four places. It can come from an external pin, or from an internal clock that the block also drives out to the modulator. It can also be that internal clock divided by two, with the divided clock toggling either on the falling or on the rising transitions of the internal clock. The serial clock and data are brought into the system clock domain through a two-stage synchroniser, and all edges are found in that domain. The data can come from the channel's own pin or from a neighbouring pin. A channel enable stops all output when cleared.

The output is a valid/ready stream with a single holding register. The modulator cannot be paused, so back-pressure never stalls the input. If a new bit arrives while an earlier one is still waiting for `out_ready`, the new bit overwrites the old one and `out_overrun` pulses for one cycle. If the held bit is taken in the same cycle that a new bit arrives, the new bit is loaded and no overrun is signalled.

Top module: `sd_bitstream_rx`

## Requirements
- R1: With `cfg_format` = 0, one bit is delivered for every rising edge of the selected serial clock, and it carries the data level present at that edge.
- R2: With `cfg_format` = 1, one bit is delivered for every falling edge of the selected serial clock, and rising edges deliver nothing.
- R3: With `cfg_format` = 2, the Manchester line is decoded so that a low-to-high transition at mid-bit gives 0 and a high-to-low transition gives 1.
- R4: With `cfg_format` = 3, the Manchester polarity is reversed: low-to-high at mid-bit gives 1 and high-to-low gives 0.
- R5: `cfg_clk_src` selects the serial clock. Code 0 is `sclk_in`. Code 1 is `sclk_out`, which toggles every `SCLK_HALF` system cycles while enabled. Code 2 is `sclk_out` divided by two, toggling on its falling transitions. Code 3 is `sclk_out` divided by two, toggling on its rising transitions. The first capture with code 2 therefore comes exactly `SCLK_HALF` cycles later than with code 3.
- R6: While `cfg_enable` is low, no bit is delivered, and `sclk_out`, `out_valid`, `out_overrun` and `dec_err` stay low.
- R7: With `cfg_alt_sel` high, data is taken from `sdat_alt` and `sdat_own` is ignored. With it low, the reverse applies.
- R8: In the Manchester formats, `dec_err` rises once four half-bit periods (`cfg_half_bit` cycles each) pass with no accepted mid-bit transition. It clears at the next accepted transition.
- R9: A delivered bit 1 appears as `out_sample` = 2'b01 (+1) and a bit 0 as 2'b11 (-1). `out_sample` is 2'b00 when no bit is held.
- R10: A held bit stays valid until `out_ready` is seen high. A new bit arriving while the held one is not taken replaces it and pulses `out_overrun` for one cycle. A new bit arriving in the cycle the held bit is taken is loaded with no overrun.
- R11: After reset, `out_valid`, `out_overrun`, `dec_err` and `sclk_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Channel enable |
| cfg_format | input | 2 | Line format: 0 rise capture, 1 fall capture, 2/3 Manchester |
| cfg_clk_src | input | 2 | Serial clock source select |
| cfg_alt_sel | input | 1 | Take data from the neighbouring pin |
| cfg_half_bit | input | CNT_W | Manchester half-bit length in system cycles |
| sclk_in | input | 1 | External serial clock |
| sdat_own | input | 1 | Channel's own serial data pin |
| sdat_alt | input | 1 | Neighbouring serial data pin |
| sclk_out | output | 1 | Internally generated serial clock |
| out_valid | output | 1 | A bit is held for the filter |
| out_ready | input | 1 | Filter takes the held bit |
| out_sample | output | 2 | Signed sample: +1, -1, or 0 when idle |
| out_overrun | output | 1 | One-cycle pulse: an untaken bit was overwritten |
| dec_err | output | 1 | Manchester timing lost |

## Verification
The two functions that can coincide are the filter taking the held bit and the front end delivering the next one. Because the synchroniser latency is fixed, the bench can count the cycles from its own serial clock edge and raise `out_ready` for exactly the cycle in which the new bit is loaded. It then judges the result at the ports. The old bit must be seen taken. The new bit must remain valid with the correct sign, and `out_overrun` must stay silent. The same coincidence with `out_ready` held low must instead produce exactly one overrun pulse for each overwritten bit.

// File: rtl/sdrx_pkg.sv
package sdrx_pkg;

  typedef enum logic [1:0] {
    FMT_CLK_RISE = 2'd0,
    FMT_CLK_FALL = 2'd1,
    FMT_MAN_R0   = 2'd2,
    FMT_MAN_R1   = 2'd3
  } sd_fmt_e;

  typedef enum logic [1:0] {
    SRC_EXT    = 2'd0,
    SRC_INT    = 2'd1,
    SRC_HALF_F = 2'd2,
    SRC_HALF_R = 2'd3
  } sd_src_e;

  localparam logic [1:0] SAMPLE_POS  = 2'b01;
  localparam logic [1:0] SAMPLE_NEG  = 2'b11;
  localparam logic [1:0] SAMPLE_NONE = 2'b00;

endpackage

// File: rtl/sdrx_sync.sv
module sdrx_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= '0;
    else        pipe[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[g] <= '0;
      else        pipe[g] <= pipe[g-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/sdrx_clkgen.sv
module sdrx_clkgen #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic sclk,
  output logic half_f,
  output logic half_r
);

  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      sclk   <= 1'b0;
      half_f <= 1'b0;
      half_r <= 1'b0;
    end else if (!en) begin
      cnt    <= '0;
      sclk   <= 1'b0;
      half_f <= 1'b0;
      half_r <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      sclk <= ~sclk;
      if (sclk) half_f <= ~half_f;   // sclk about to fall
      else      half_r <= ~half_r;   // sclk about to rise
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sdrx_manch.sv
module sdrx_manch #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             inv,
  input  logic [CNT_W-1:0] half_bit,
  input  logic             lvl,
  output logic             bit_evt,
  output logic             bit_val,
  output logic             err
);

  localparam int CW = CNT_W + 3;

  logic          lvl_q;
  logic          locked;
  logic [CW-1:0] cnt;
  logic [CW-1:0] blank;
  logic [CW-1:0] tmo;
  logic          line_edge;

  // Transitions closer than 3/4 bit to the last mid-bit are boundary ones.
  assign blank     = CW'(half_bit) + CW'(half_bit >> 1);
  assign tmo       = CW'(half_bit) << 2;
  assign line_edge = lvl ^ lvl_q;
  assign bit_evt   = en && line_edge && (!locked || cnt >= blank);
  assign bit_val   = inv ? lvl : ~lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      locked <= 1'b0;
      err    <= 1'b0;
    end else if (!en) begin
      cnt    <= '0;
      locked <= 1'b0;
      err    <= 1'b0;
    end else if (bit_evt) begin
      cnt    <= '0;
      locked <= 1'b1;
      err    <= 1'b0;
    end else begin
      if (cnt != '1) cnt <= cnt + 1'b1;
      if (cnt == tmo) begin
        err    <= 1'b1;
        locked <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sd_bitstream_rx.sv
module sd_bitstream_rx
  import sdrx_pkg::*;
#(
  parameter int SCLK_HALF   = 4,
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic [1:0]       cfg_format,
  input  logic [1:0]       cfg_clk_src,
  input  logic             cfg_alt_sel,
  input  logic [CNT_W-1:0] cfg_half_bit,
  input  logic             sclk_in,
  input  logic             sdat_own,
  input  logic             sdat_alt,
  output logic             sclk_out,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [1:0]       out_sample,
  output logic             out_overrun,
  output logic             dec_err
);

  sd_fmt_e fmt;
  sd_src_e src;
  assign fmt = sd_fmt_e'(cfg_format);
  assign src = sd_src_e'(cfg_clk_src);

  // internal clock and its divided forms
  logic half_f, half_r;
  sdrx_clkgen #(.HALF(SCLK_HALF)) u_clkgen (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (cfg_enable),
    .sclk   (sclk_out),
    .half_f (half_f),
    .half_r (half_r)
  );

  // source selection ahead of the synchroniser, so clock and data align
  logic clk_raw, dat_raw;
  always_comb begin
    unique case (src)
      SRC_EXT:    clk_raw = sclk_in;
      SRC_INT:    clk_raw = sclk_out;
      SRC_HALF_F: clk_raw = half_f;
      default:    clk_raw = half_r;
    endcase
  end
  assign dat_raw = cfg_alt_sel ? sdat_alt : sdat_own;

  logic ck_s, dt_s, ck_q;
  sdrx_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({clk_raw, dat_raw}),
    .q     ({ck_s, dt_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ck_q <= 1'b0;
    else        ck_q <= ck_s;
  end

  // clocked capture
  logic ck_rise, ck_fall, cap_evt;
  assign ck_rise = ck_s & ~ck_q;
  assign ck_fall = ~ck_s & ck_q;
  assign cap_evt = cfg_enable && !fmt[1] && ((fmt == FMT_CLK_FALL) ? ck_fall : ck_rise);

  // self-clocked decode
  logic man_evt, man_bit;
  sdrx_manch #(.CNT_W(CNT_W)) u_manch (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (cfg_enable && fmt[1]),
    .inv      (fmt == FMT_MAN_R1),
    .half_bit (cfg_half_bit),
    .lvl      (dt_s),
    .bit_evt  (man_evt),
    .bit_val  (man_bit),
    .err      (dec_err)
  );

  logic new_evt, new_bit;
  assign new_evt = fmt[1] ? man_evt : cap_evt;
  assign new_bit = fmt[1] ? man_bit : dt_s;

  // single holding register towards the filter
  logic held_bit;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      held_bit    <= 1'b0;
      out_overrun <= 1'b0;
    end else if (!cfg_enable) begin
      out_valid   <= 1'b0;
      out_overrun <= 1'b0;
    end else begin
      out_overrun <= new_evt && out_valid && !out_ready;
      if (new_evt) begin
        out_valid <= 1'b1;
        held_bit  <= new_bit;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign out_sample = !out_valid ? SAMPLE_NONE : (held_bit ? SAMPLE_POS : SAMPLE_NEG);

endmodule

// File: rtl/sdrx_checker.sv
module sdrx_checker #(
  parameter int SCLK_HALF = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_enable,
  input logic [1:0] cfg_format,
  input logic       sclk_out,
  input logic       out_valid,
  input logic       out_ready,
  input logic       out_overrun,
  input logic       dec_err
);

  logic        prev_sclk;
  logic        seen_toggle;
  logic [15:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sclk   <= 1'b0;
      seen_toggle <= 1'b0;
      gap         <= '0;
    end else begin
      prev_sclk <= sclk_out;
      if (!cfg_enable) begin
        seen_toggle <= 1'b0;
        gap         <= '0;
      end else if (sclk_out != prev_sclk) begin
        seen_toggle <= 1'b1;
        gap         <= '0;
      end else if (gap != '1) begin
        gap <= gap + 1'b1;
      end
    end
  end

  assert_sclk_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && seen_toggle && sclk_out != prev_sclk) |-> (gap == 16'(SCLK_HALF - 1)));

  assert_quiet_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> (!out_valid && !out_overrun && !dec_err && !sclk_out));

  assert_err_scope_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err |-> $past(cfg_enable && cfg_format[1]));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && cfg_enable) |=> out_valid);

  assert_ovr_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_overrun |-> $past(out_valid && !out_ready));

endmodule

bind sd_bitstream_rx sdrx_checker #(.SCLK_HALF(SCLK_HALF)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_enable  (cfg_enable),
  .cfg_format  (cfg_format),
  .sclk_out    (sclk_out),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_overrun (out_overrun),
  .dec_err     (dec_err)
);

// File: tb/sim_sd_bitstream_rx.sv
module sim_sd_bitstream_rx;

  localparam int SCLK_HALF = 4;
  localparam int CNT_W     = 10;
  localparam int HB        = 8;   // Manchester half-bit, system cycles
  localparam int SP        = 8;   // external serial clock half period

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_enable = 1'b0;
  logic [1:0]       cfg_format = 2'd0;
  logic [1:0]       cfg_clk_src = 2'd0;
  logic             cfg_alt_sel = 1'b0;
  logic [CNT_W-1:0] cfg_half_bit = CNT_W'(HB);
  logic             sclk_in = 1'b0;
  logic             sdat_own = 1'b0;
  logic             sdat_alt = 1'b0;
  logic             sclk_out;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [1:0]       out_sample;
  logic             out_overrun;
  logic             dec_err;

  sd_bitstream_rx #(.SCLK_HALF(SCLK_HALF), .CNT_W(CNT_W), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_format(cfg_format),
    .cfg_clk_src(cfg_clk_src), .cfg_alt_sel(cfg_alt_sel), .cfg_half_bit(cfg_half_bit),
    .sclk_in(sclk_in), .sdat_own(sdat_own), .sdat_alt(sdat_alt), .sclk_out(sclk_out),
    .out_valid(out_valid), .out_ready(out_ready), .out_sample(out_sample),
    .out_overrun(out_overrun), .dec_err(dec_err)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // handshake monitor, sampling after the bench has driven its inputs
  logic rx_bits [256];
  int   rx_n = 0;
  int   ovr_n = 0;
  int   enc_bad = 0;
  always begin
    @(negedge clk);
    #1;
    if (out_valid && out_ready) begin
      rx_bits[rx_n % 256] <= (out_sample == 2'b01);
      rx_n <= rx_n + 1;
      if (out_sample != 2'b01 && out_sample != 2'b11) enc_bad <= enc_bad + 1;
    end
    if (out_overrun) ovr_n <= ovr_n + 1;
  end

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_line(input logic alt, input logic v);
    if (alt) begin sdat_alt = v; sdat_own = ~v; end
    else     begin sdat_own = v; sdat_alt = ~v; end
  endtask

  // clocked stream on the external clock, MSB first
  task automatic send_clk(input logic [1:0] fmt, input logic alt, input logic [7:0] pat, input int nb);
    for (int i = nb - 1; i >= 0; i--) begin
      sclk_in = (fmt == 2'd1);
      set_line(alt, pat[i]);
      wait_cyc(SP);
      sclk_in = (fmt != 2'd1);
      wait_cyc(SP);
    end
  endtask

  function automatic logic man_first(input logic [1:0] fmt, input logic b);
    return (fmt == 2'd2) ? b : ~b;
  endfunction

  task automatic send_man(input logic [1:0] fmt, input logic alt, input logic [7:0] pat, input int nb);
    for (int i = nb - 1; i >= 0; i--) begin
      set_line(alt, man_first(fmt, pat[i]));
      wait_cyc(HB);
      set_line(alt, ~man_first(fmt, pat[i]));
      wait_cyc(HB);
    end
  endtask

  function automatic logic [7:0] grab(input int start);
    logic [7:0] g = '0;
    for (int i = 0; i < 8; i++) g = {g[6:0], rx_bits[(start + i) % 256]};
    return g;
  endfunction

  task automatic measure_first(input logic [1:0] src, output int dly);
    int start, t0;
    cfg_enable  = 1'b0;
    cfg_clk_src = src;
    cfg_format  = 2'd0;
    set_line(1'b0, 1'b1);
    wait_cyc(4);
    start = rx_n;
    cfg_enable = 1'b1;
    t0 = cyc;
    while (rx_n == start) @(negedge clk);
    dly = cyc - t0;
    cfg_enable = 1'b0;
    wait_cyc(4);
  endtask

  // {format, alt pin, stimulus pattern, expected bits}
  localparam logic [18:0] VEC [7] = '{
    {2'd0, 1'b0, 8'hA5, 8'hA5},   // R1
    {2'd1, 1'b0, 8'h3C, 8'h3C},   // R2
    {2'd2, 1'b0, 8'hB1, 8'hB1},   // R3
    {2'd3, 1'b0, 8'h4E, 8'h4E},   // R4
    {2'd0, 1'b1, 8'h96, 8'h96},   // R7
    {2'd2, 1'b1, 8'h0F, 8'h0F},   // R7 with R3
    {2'd3, 1'b0, 8'hF0, 8'hF0}    // R4
  };

  initial begin
    int start, o0, tmp, ones, d_r, d_f, t1, t2;
    logic [1:0]  vf;
    logic        va;
    logic [7:0]  vp, ve;

    // R11: reset state
    wait_cyc(3);
    chk("R11 out_valid in reset", int'(out_valid), 0);
    chk("R11 sclk_out in reset", int'(sclk_out), 0);
    rst_n = 1'b1;
    wait_cyc(3);
    chk("R11 out_overrun after reset", int'(out_overrun), 0);
    chk("R11 dec_err after reset", int'(dec_err), 0);
    chk("R9 idle sample", int'(out_sample), 0);

    // table of formats and pin choices on the external clock
    foreach (VEC[k]) begin
      {vf, va, vp, ve} = VEC[k];
      cfg_enable  = 1'b0;
      cfg_format  = vf;
      cfg_alt_sel = va;
      cfg_clk_src = 2'd0;
      sclk_in     = (vf == 2'd1);
      set_line(va, vf[1] ? man_first(vf, vp[7]) : 1'b0);
      wait_cyc(6);
      start = rx_n;
      cfg_enable = 1'b1;
      wait_cyc(2);
      if (vf[1]) send_man(vf, va, vp, 8);
      else       send_clk(vf, va, vp, 8);
      wait_cyc(6);
      chk($sformatf("R1/R2/R3/R4/R7 vec%0d bit count", k), rx_n - start, 8);
      chk($sformatf("R1/R2/R3/R4/R7 vec%0d bits", k), int'(grab(start)), int'(ve));
      cfg_enable = 1'b0;
      wait_cyc(4);
    end
    chk("R9 encoding of all delivered samples", enc_bad, 0);

    // R6: disabled channel ignores a clocked stream
    cfg_alt_sel = 1'b0;
    cfg_format  = 2'd0;
    sclk_in     = 1'b0;
    start = rx_n;
    send_clk(2'd0, 1'b0, 8'hFF, 8);
    wait_cyc(6);
    chk("R6 no bits while disabled", rx_n - start, 0);
    chk("R6 sclk_out low while disabled", int'(sclk_out), 0);
    chk("R6 out_valid low while disabled", int'(out_valid), 0);

    // R8: Manchester timing loss and recovery
    cfg_format = 2'd2;
    set_line(1'b0, man_first(2'd2, 1'b1));
    wait_cyc(6);
    cfg_enable = 1'b1;
    wait_cyc(2);
    send_man(2'd2, 1'b0, 8'h02, 2);
    wait_cyc(2 * HB);
    chk("R8 no error within two bit periods", int'(dec_err), 0);
    wait_cyc(4 * HB);
    chk("R8 error after silent line", int'(dec_err), 1);
    send_man(2'd2, 1'b0, 8'h01, 1);
    wait_cyc(4);
    chk("R8 error clears on transition", int'(dec_err), 0);
    cfg_enable = 1'b0;
    wait_cyc(4);

    // R10: overwrite while not taken
    cfg_format = 2'd0;
    sclk_in    = 1'b0;
    set_line(1'b0, 1'b0);
    out_ready  = 1'b0;
    wait_cyc(4);
    cfg_enable = 1'b1;
    wait_cyc(2);
    o0 = ovr_n;
    start = rx_n;
    send_clk(2'd0, 1'b0, 8'h05, 3);
    wait_cyc(6);
    chk("R10 overrun pulses for two overwrites", ovr_n - o0, 2);
    chk("R10 held bit still valid", int'(out_valid), 1);
    chk("R9 held +1 sample", int'(out_sample), 1);
    out_ready = 1'b1;
    wait_cyc(2);
    chk("R10 one bit taken", rx_n - start, 1);
    chk("R10 taken bit is newest", int'(rx_bits[start % 256]), 1);
    chk("R10 valid drops after take", int'(out_valid), 0);

    // R10: take and arrival in the same cycle
    out_ready = 1'b0;
    send_clk(2'd0, 1'b0, 8'h00, 1);
    wait_cyc(4);
    chk("R9 held -1 sample", int'(out_sample), 3);
    o0 = ovr_n;
    start = rx_n;
    sclk_in = 1'b0;
    set_line(1'b0, 1'b1);
    wait_cyc(SP);
    sclk_in = 1'b1;
    wait_cyc(2);
    out_ready = 1'b1;
    wait_cyc(1);
    out_ready = 1'b0;
    chk("R10 same-cycle: old bit taken", rx_n - start, 1);
    chk("R10 same-cycle: old bit value", int'(rx_bits[start % 256]), 0);
    chk("R10 same-cycle: no overrun", ovr_n - o0, 0);
    chk("R10 same-cycle: new bit held", int'(out_sample), 1);
    out_ready = 1'b1;
    wait_cyc(2);
    cfg_enable = 1'b0;
    wait_cyc(4);

    // R5: internal clock period and rates
    cfg_clk_src = 2'd1;
    set_line(1'b0, 1'b1);
    wait_cyc(4);
    cfg_enable = 1'b1;
    tmp = int'(sclk_out);
    while (int'(sclk_out) == tmp) @(negedge clk);
    t1 = cyc;
    tmp = int'(sclk_out);
    while (int'(sclk_out) == tmp) @(negedge clk);
    t2 = cyc;
    chk("R5 sclk_out half period", t2 - t1, SCLK_HALF);
    start = rx_n;
    wait_cyc(160);
    chk_rng("R5 full-rate internal bit count", rx_n - start,
            160 / (2 * SCLK_HALF) - 1, 160 / (2 * SCLK_HALF) + 1);
    ones = 0;
    for (int i = start; i < rx_n; i++) ones += int'(rx_bits[i % 256]);
    chk("R5 internal captures carry data", ones, rx_n - start);
    cfg_enable = 1'b0;
    wait_cyc(4);
    cfg_clk_src = 2'd2;
    cfg_enable  = 1'b1;
    start = rx_n;
    wait_cyc(160);
    chk_rng("R5 half-rate internal bit count", rx_n - start,
            160 / (4 * SCLK_HALF) - 1, 160 / (4 * SCLK_HALF) + 1);
    cfg_enable = 1'b0;
    wait_cyc(4);
    measure_first(2'd3, d_r);
    measure_first(2'd2, d_f);
    chk("R5 falling-qualified half clock lags by SCLK_HALF", d_f - d_r, SCLK_HALF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail + 1);
    $finish;
  end

endmodule